// File: doc/BRIEF.md
# Table-Driven Sine PWM Generator

This block turns a built-in 256-point sine table into a pulse-width-modulated output. The output is meant for an external low-pass filter. A sample-rate divider fires a tick once every N enabled clocks. On each tick a phase index steps forward by one, modulo 256, and the table entry at the new index becomes the current sample. A free-running 8-bit carrier counter compares its count against an active duty register. That register takes the newest sample only when the carrier wraps back to zero.

The sample clock and the carrier are independent. The nominal output frequency is f_clk / (256 · N). For example, a 16 MHz clock with N = 100 gives 625 Hz. When samples arrive faster than one per 256-clock carrier period, the double-buffered duty register keeps each period intact. Only the latest sample is applied at the next wrap, and the earlier ones are dropped.

Top module: `sine_pwm_gen`

## Requirements
- R1: After reset the sample output and the active duty are 127 and the strobe is low. The first full carrier period therefore holds the output high for 127 of its 256 clocks.
- R2: With a divider value N ≥ 1, a tick occurs every N enabled clocks. The strobe output is high for exactly one clock per tick, in the same cycle that the new sample appears on the sample output.
- R3: A divider value of 0 behaves as 1, giving a tick on every enabled clock.
- R4: A divider value changed mid-interval does not shorten or lengthen the interval in progress. It governs the intervals that follow the next tick.
- R5: Each tick advances the index by one, wrapping 255 to 0, and outputs entry idx = 128 + trunc(127·sin(2π·idx/256)). After reset the index is 0, so the first tick yields entry 1. Index 0 gives 128, index 64 gives 255 and index 192 gives 1.
- R6: The carrier period is 256 clocks. The output is high from carrier count 0 up to count duty−1 and low for the rest, so it is high for exactly duty clocks per period.
- R7: The active duty loads from the sample output only when the carrier wraps from 255 to 0. A period's high time equals the sample present at the end of the previous period, and samples replaced within one period are never applied.
- R8: While enable is low, the PWM output is low. The divider, index and carrier hold their state and no strobe occurs. After enable returns, the interval resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low freezes the block and forces the output low |
| div_n | input | DIV_W | Sample interval in clocks (0 treated as 1) |
| pwm_o | output | 1 | Pulse-width-modulated output |
| sample_o | output | 8 | Most recent table sample |
| strobe_o | output | 1 | One-clock pulse with each new sample |

## Verification
The bench builds the block with its defaults: a 16-bit divider and a reset duty of 127. This lets it drive divider values from 0 and 1 up to 1000. A divider of 1 sweeps the whole table in 256 clocks, including the wrap and the extreme entries. A divider of 100 puts two or three samples inside each carrier period, which exercises the drop of superseded samples. A divider of 300 gives less than one sample per period, and a divider of 1000 keeps the reset duty in place across the first full period.

// File: rtl/sine_pwm_gen.sv
module sine_pwm_gen #(
  parameter int DIV_W      = 16,
  parameter int RESET_DUTY = 127
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div_n,
  output logic             pwm_o,
  output logic [7:0]       sample_o,
  output logic             strobe_o
);
  localparam int         PW    = 8;
  localparam logic [PW-1:0] TOP  = '1;
  localparam logic [PW-1:0] RDUTY = PW'(RESET_DUTY);

  function automatic logic [6:0] quarter(input logic [5:0] k);
    case (k)
      6'd0:  return 7'd0;   6'd1:  return 7'd3;   6'd2:  return 7'd6;   6'd3:  return 7'd9;
      6'd4:  return 7'd12;  6'd5:  return 7'd15;  6'd6:  return 7'd18;  6'd7:  return 7'd21;
      6'd8:  return 7'd24;  6'd9:  return 7'd27;  6'd10: return 7'd30;  6'd11: return 7'd33;
      6'd12: return 7'd36;  6'd13: return 7'd39;  6'd14: return 7'd42;  6'd15: return 7'd45;
      6'd16: return 7'd48;  6'd17: return 7'd51;  6'd18: return 7'd54;  6'd19: return 7'd57;
      6'd20: return 7'd59;  6'd21: return 7'd62;  6'd22: return 7'd65;  6'd23: return 7'd67;
      6'd24: return 7'd70;  6'd25: return 7'd73;  6'd26: return 7'd75;  6'd27: return 7'd78;
      6'd28: return 7'd80;  6'd29: return 7'd82;  6'd30: return 7'd85;  6'd31: return 7'd87;
      6'd32: return 7'd89;  6'd33: return 7'd91;  6'd34: return 7'd94;  6'd35: return 7'd96;
      6'd36: return 7'd98;  6'd37: return 7'd100; 6'd38: return 7'd102; 6'd39: return 7'd103;
      6'd40: return 7'd105; 6'd41: return 7'd107; 6'd42: return 7'd108; 6'd43: return 7'd110;
      6'd44: return 7'd112; 6'd45: return 7'd113; 6'd46: return 7'd114; 6'd47: return 7'd116;
      6'd48: return 7'd117; 6'd49: return 7'd118; 6'd50: return 7'd119; 6'd51: return 7'd120;
      6'd52: return 7'd121; 6'd53: return 7'd122; 6'd54: return 7'd123; 6'd55: return 7'd123;
      6'd56: return 7'd124; 6'd57: return 7'd125; 6'd58: return 7'd125; 6'd59: return 7'd126;
      6'd60: return 7'd126; 6'd61: return 7'd126; 6'd62: return 7'd126; default: return 7'd126;
    endcase
  endfunction

  function automatic logic [7:0] wave(input logic [7:0] i);
    logic [6:0] j;
    logic [6:0] q;
    j = i[6] ? (7'd64 - {1'b0, i[5:0]}) : {1'b0, i[5:0]};
    q = (j == 7'd64) ? 7'd127 : quarter(j[5:0]);
    return i[7] ? (8'd128 - {1'b0, q}) : (8'd128 + {1'b0, q});
  endfunction

  logic [DIV_W-1:0] div_cnt, n_act, n_eff;
  logic [7:0]       idx, sample_q, pwm_cnt, duty_act;
  logic             strobe_q, tick;

  assign n_eff = (div_n == '0) ? DIV_W'(1) : div_n;
  assign tick  = en && (div_cnt == n_act - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      n_act   <= n_eff;
    end else if (tick) begin
      div_cnt <= '0;
      n_act   <= n_eff;
    end else if (en) begin
      div_cnt <= div_cnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx      <= '0;
      sample_q <= RDUTY;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= tick;
      if (tick) begin
        idx      <= idx + 8'd1;
        sample_q <= wave(idx + 8'd1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_cnt  <= '0;
      duty_act <= RDUTY;
    end else if (en) begin
      pwm_cnt <= pwm_cnt + 8'd1;
      if (pwm_cnt == TOP) duty_act <= sample_q;
    end
  end

  assign pwm_o    = en && (pwm_cnt < duty_act);
  assign sample_o = sample_q;
  assign strobe_o = strobe_q;
endmodule

// File: rtl/sine_pwm_gen_chk.sv
module sine_pwm_gen_chk #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             pwm_o,
  input logic             strobe_o,
  input logic [7:0]       sample_o,
  input logic [7:0]       pwm_cnt,
  input logic [DIV_W-1:0] div_cnt,
  input logic [7:0]       duty_act
);
  // R8
  disabled_low_chk: assert property (@(posedge clk) disable iff (rst) !en |-> !pwm_o);

  // R8
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(pwm_cnt) && $stable(div_cnt)));

  // R8
  no_strobe_off_chk: assert property (@(posedge clk) disable iff (rst) strobe_o |-> $past(en));

  // R7
  duty_at_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(duty_act) |-> ($past(pwm_cnt) == 8'hFF));

  // R6
  bottom_high_chk: assert property (@(posedge clk) disable iff (rst)
    (en && pwm_cnt == 8'd0) |-> pwm_o);

  // R2
  sample_with_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sample_o) |-> strobe_o);
endmodule

bind sine_pwm_gen sine_pwm_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .pwm_o(pwm_o), .strobe_o(strobe_o),
  .sample_o(sample_o), .pwm_cnt(pwm_cnt), .div_cnt(div_cnt), .duty_act(duty_act)
);

// File: tb/sine_pwm_gen_test.sv
`timescale 1ns/1ps
module sine_pwm_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [15:0] div_n = 16'd1;
  logic        pwm_o, strobe_o;
  logic [7:0]  sample_o;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  sine_pwm_gen uut (.clk(clk), .rst(rst), .en(en), .div_n(div_n),
                    .pwm_o(pwm_o), .sample_o(sample_o), .strobe_o(strobe_o));

  function automatic int tbl(int i);
    real v;
    v = 127.0 * $sin(2.0 * 3.14159265358979 * (i % 256) / 256.0);
    return 128 + $rtoi(v);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(int n);
    en = 1'b0;
    div_n = 16'(n);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_strobe(output int c);
    c = 0;
    do begin
      @(negedge clk);
      c++;
    end while (!strobe_o && c < 5000);
  endtask

  task automatic measure_periods(int count, string req);
    bit prev_p = 1'b1;
    bit started = 1'b0;
    int last_s = sample_o;
    int hi = 0, len = 0, exp = 0, done_p = 0;
    while (done_p < count) begin
      @(negedge clk);
      if (pwm_o && !prev_p) begin
        if (started) begin
          check(hi == exp, req, hi, exp);
          check(len == 256, "R6 period length", len, 256);
          done_p++;
        end
        started = 1'b1;
        exp = last_s;
        hi = 0;
        len = 0;
      end
      if (started) begin
        len++;
        hi += int'(pwm_o);
      end
      prev_p = pwm_o;
      last_s = sample_o;
    end
  endtask

  task automatic t_reset;
    do_reset(1000);
    @(negedge clk);
    check(sample_o == 8'd127, "R1 reset sample", sample_o, 127);
    check(strobe_o == 1'b0, "R1 reset strobe", strobe_o, 0);
    check(pwm_o == 1'b0, "R8 output low when disabled", pwm_o, 0);
    en = 1'b1;
    measure_periods(1, "R1 first period duty");
  endtask

  task automatic t_sequence;
    do_reset(1);
    en = 1'b1;
    for (int k = 1; k <= 300; k++) begin
      @(negedge clk);
      check(strobe_o == 1'b1, "R2 strobe every tick", strobe_o, 1);
      check(sample_o == tbl(k), "R5 table sequence", sample_o, tbl(k));
      if (k == 64)  check(sample_o == 8'd255, "R5 peak", sample_o, 255);
      if (k == 192) check(sample_o == 8'd1, "R5 trough", sample_o, 1);
      if (k == 256) check(sample_o == 8'd128, "R5 index wrap", sample_o, 128);
    end
  endtask

  task automatic t_zero;
    do_reset(0);
    en = 1'b1;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      check(strobe_o == 1'b1, "R3 zero divider acts as one", strobe_o, 1);
    end
  endtask

  task automatic t_spacing(int n);
    int c;
    do_reset(n);
    en = 1'b1;
    for (int k = 0; k < 4; k++) begin
      wait_strobe(c);
      check(c == n, "R2 tick spacing", c, n);
      @(negedge clk);
      check(strobe_o == 1'b0, "R2 strobe one clock", strobe_o, 0);
      wait_strobe(c);
      check(c == n - 1, "R2 tick spacing", c + 1, n);
    end
  endtask

  task automatic t_change;
    int c;
    do_reset(10);
    en = 1'b1;
    wait_strobe(c);
    check(c == 10, "R4 initial interval", c, 10);
    repeat (3) @(negedge clk);
    div_n = 16'd4;
    wait_strobe(c);
    check(c == 7, "R4 interval in progress kept", c, 7);
    wait_strobe(c);
    check(c == 4, "R4 new interval applied", c, 4);
    wait_strobe(c);
    check(c == 4, "R4 new interval applied", c, 4);
  endtask

  task automatic t_pwm;
    do_reset(100);
    en = 1'b1;
    measure_periods(6, "R7 duty from latest sample");
    do_reset(300);
    en = 1'b1;
    measure_periods(4, "R6 high time equals duty");
  endtask

  task automatic t_enable;
    int c;
    logic [7:0] hold;
    do_reset(10);
    en = 1'b1;
    wait_strobe(c);
    repeat (4) @(negedge clk);
    en = 1'b0;
    hold = sample_o;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      check(pwm_o == 1'b0, "R8 output low", pwm_o, 0);
      check(strobe_o == 1'b0, "R8 no strobe", strobe_o, 0);
      check(sample_o == hold, "R8 sample held", sample_o, hold);
    end
    en = 1'b1;
    wait_strobe(c);
    check(c == 6, "R8 interval resumes", c, 6);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_sequence();
    t_zero();
    t_spacing(5);
    t_spacing(37);
    t_change();
    t_pwm();
    t_enable();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule